// File: doc/BRIEF.md
# Interrupt Source Lifecycle Tracker

This block follows the life of every interrupt source in a small bank. Each source moves through four states: idle, waiting for service, being serviced, and being serviced with a further instance waiting. The state tells software-visible logic and a downstream arbiter where each source is in its service cycle. Each source runs in one of two modes, chosen per source by an input bit. In level mode the line itself holds the source asserted. In edge mode only a low-to-high transition of the line counts as a new instance.

The core side drives two single-cycle strobes per source. An acknowledge takes a waiting source into service. A completion strobe ends service. For each source the block raises a request toward the core when the source is waiting, is enabled, and beats a priority mask. The request falls as soon as the source is acknowledged. Choosing between competing requests is left to logic outside this block. The number of sources and the width of the priority field are parameters.

Top module: `irq_lifecycle_bank`

## Requirements
- R1: While reset is asserted and just after it, every source reads state 00 and no request is raised.
- R2: The state of each source is encoded as 00 idle, 01 waiting, 10 in service, 11 in service with another instance waiting. An idle source moves to 01 on the next clock edge when its line is high (level mode, mode bit 0) or has just risen from low to high (edge mode, mode bit 1).
- R3: In level mode, an acknowledge to a waiting source gives 11 if the line is still high, or 10 if the line is low.
- R4: In level mode, state 11 falls to 10 when the line is low and no completion arrives.
- R5: In level mode, a completion in state 10 or 11 with the line low gives 00.
- R6: In edge mode, an acknowledge to a waiting source gives 10 when no new rising edge arrives in the same cycle.
- R7: In edge mode, a rising edge in state 10 gives 11. A completion that arrives in the same cycle as the rising edge gives 01.
- R8: In edge mode, a completion in state 11 gives 01, and the request to the core rises again.
- R9: A source's request is high only when its state is 01, its enable is 1, and its priority value is strictly below the mask. A lower priority value means higher urgency.
- R10: In edge mode, a rising edge that arrives while the source is in 01 or 11 merges with the instance already waiting, and the state does not change.
- R11: An acknowledge aimed at a source that is not in 01 is ignored. A completion aimed at a source in 00 or 01 is ignored. In both cases the state is unchanged.
- R12: In level mode, a waiting source whose line drops before it is acknowledged returns to 00.
- R13: In level mode, a completion in state 10 or 11 while the line is still high gives 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | N_SRC | Raw interrupt line of each source |
| src_en | input | N_SRC | Per-source enable for the request |
| src_edge | input | N_SRC | Mode per source: 1 edge, 0 level |
| ack_stb | input | N_SRC | Acknowledge strobe per source |
| eoi_stb | input | N_SRC | Completion strobe per source |
| src_prio | input | N_SRC*PRIO_W | Priority value per source, source 0 in the low bits |
| prio_mask | input | PRIO_W | Request threshold; a source qualifies when its value is below it |
| lc_state | output | 2*N_SRC | Two-bit state per source, source 0 in the low bits |
| core_req | output | N_SRC | Request to the core per source |

## Verification
The hardest cases are a strobe from the core and a change on the line that land in the same clock cycle. Examples are a completion that meets a fresh rising edge, and an acknowledge that meets a dropping level. The directed table places these pairs deliberately, one vector per pair, for both modes at once. The expected state for each pair is worked out by hand from the requirements. A long random phase then drives lines, strobes and enables freely on every source. It compares each cycle against a state model kept in the bench, which catches the coincidences the table does not list.

// File: rtl/irq_lc_pkg.sv
package irq_lc_pkg;

   typedef enum logic [1:0] {
      LC_IDLE = 2'b00,
      LC_PEND = 2'b01,
      LC_ACTV = 2'b10,
      LC_BOTH = 2'b11
   } lc_state_e;

   localparam int unsigned LC_STATE_W = 2;

endpackage

// File: rtl/irq_lc_edge.sv
module irq_lc_edge #(
   parameter int unsigned N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] line,
   output logic [N_SRC-1:0] rise
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_hist
      logic line_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q <= 1'b0;
         else        line_q <= line[i];
      end

      assign rise[i] = line[i] & ~line_q;
   end

endmodule

// File: rtl/irq_lc_fsm.sv
module irq_lc_fsm
   import irq_lc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      line,
   input  logic      rise,
   input  logic      edge_mode,
   input  logic      ack,
   input  logic      eoi,
   output lc_state_e state
);

   lc_state_e st_q;
   lc_state_e nxt_lvl;
   lc_state_e nxt_edg;

   // level mode: the line itself stands for a waiting instance
   always_comb begin
      nxt_lvl = st_q;
      unique case (st_q)
         LC_IDLE: if (line) nxt_lvl = LC_PEND;
         LC_PEND: begin
            if (ack)        nxt_lvl = line ? LC_BOTH : LC_ACTV;
            else if (!line) nxt_lvl = LC_IDLE;
         end
         LC_ACTV: begin
            if (eoi)       nxt_lvl = line ? LC_PEND : LC_IDLE;
            else if (line) nxt_lvl = LC_BOTH;
         end
         LC_BOTH: begin
            if (eoi)        nxt_lvl = line ? LC_PEND : LC_IDLE;
            else if (!line) nxt_lvl = LC_ACTV;
         end
         default: nxt_lvl = LC_IDLE;
      endcase
   end

   // edge mode: only a fresh rising edge adds an instance, extra edges merge
   always_comb begin
      nxt_edg = st_q;
      unique case (st_q)
         LC_IDLE: if (rise) nxt_edg = LC_PEND;
         LC_PEND: if (ack)  nxt_edg = rise ? LC_BOTH : LC_ACTV;
         LC_ACTV: begin
            if (eoi)       nxt_edg = rise ? LC_PEND : LC_IDLE;
            else if (rise) nxt_edg = LC_BOTH;
         end
         LC_BOTH: if (eoi)  nxt_edg = LC_PEND;
         default: nxt_edg = LC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LC_IDLE;
      else        st_q <= edge_mode ? nxt_edg : nxt_lvl;
   end

   assign state = st_q;

endmodule

// File: rtl/irq_lc_gate.sv
module irq_lc_gate
   import irq_lc_pkg::*;
#(
   parameter int unsigned N_SRC  = 4,
   parameter int unsigned PRIO_W = 4,
   localparam int unsigned ST_W  = LC_STATE_W * N_SRC,
   localparam int unsigned PR_W  = PRIO_W * N_SRC
) (
   input  logic [ST_W-1:0]   state,
   input  logic [N_SRC-1:0]  en,
   input  logic [PR_W-1:0]   prio,
   input  logic [PRIO_W-1:0] mask,
   output logic [N_SRC-1:0]  req
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_req
      logic waiting;
      logic urgent;
      assign waiting = (state[LC_STATE_W*i +: LC_STATE_W] == LC_PEND);
      assign urgent  = (prio[PRIO_W*i +: PRIO_W] < mask);
      assign req[i]  = waiting & en[i] & urgent;
   end

endmodule

// File: rtl/irq_lifecycle_bank.sv
module irq_lifecycle_bank
   import irq_lc_pkg::*;
#(
   parameter int unsigned N_SRC  = 4,
   parameter int unsigned PRIO_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_SRC-1:0]          irq_line,
   input  logic [N_SRC-1:0]          src_en,
   input  logic [N_SRC-1:0]          src_edge,
   input  logic [N_SRC-1:0]          ack_stb,
   input  logic [N_SRC-1:0]          eoi_stb,
   input  logic [N_SRC*PRIO_W-1:0]   src_prio,
   input  logic [PRIO_W-1:0]         prio_mask,
   output logic [2*N_SRC-1:0]        lc_state,
   output logic [N_SRC-1:0]          core_req
);

   if (N_SRC < 1 || N_SRC > 1024) begin : g_bad_nsrc
      $error("irq_lifecycle_bank: N_SRC out of range");
   end
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
      $error("irq_lifecycle_bank: PRIO_W out of range");
   end

   logic [N_SRC-1:0] rise;

   irq_lc_edge #(.N_SRC(N_SRC)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .line  (irq_line),
      .rise  (rise)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      lc_state_e st;

      irq_lc_fsm u_fsm (
         .clk       (clk),
         .rst_n     (rst_n),
         .line      (irq_line[i]),
         .rise      (rise[i]),
         .edge_mode (src_edge[i]),
         .ack       (ack_stb[i]),
         .eoi       (eoi_stb[i]),
         .state     (st)
      );

      assign lc_state[LC_STATE_W*i +: LC_STATE_W] = st;
   end

   irq_lc_gate #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_gate (
      .state (lc_state),
      .en    (src_en),
      .prio  (src_prio),
      .mask  (prio_mask),
      .req   (core_req)
   );

endmodule

// File: rtl/irq_lc_checker.sv
module irq_lc_checker #(
   parameter int unsigned N_SRC = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_SRC-1:0]   irq_line,
   input logic [N_SRC-1:0]   src_en,
   input logic [N_SRC-1:0]   src_edge,
   input logic [N_SRC-1:0]   ack_stb,
   input logic [N_SRC-1:0]   eoi_stb,
   input logic [2*N_SRC-1:0] lc_state,
   input logic [N_SRC-1:0]   core_req
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_chk
      logic [1:0] st;
      assign st = lc_state[2*i +: 2];

      a_r1_reset_idle: assert property (@(posedge clk)
         !rst_n |=> (st == 2'b00));

      a_r2_level_take: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_edge[i] && st == 2'b00 && irq_line[i]) |=> (st == 2'b01));

      a_r3_level_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_edge[i] && st == 2'b01 && ack_stb[i] && irq_line[i]) |=> (st == 2'b11));

      a_r4_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_edge[i] && st == 2'b11 && !eoi_stb[i] && !irq_line[i]) |=> (st == 2'b10));

      a_r5_level_done: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_edge[i] && st[1] && eoi_stb[i] && !irq_line[i]) |=> (st == 2'b00));

      a_r6_edge_ack: assert property (@(posedge clk) disable iff (!rst_n)
         (src_edge[i] && st == 2'b01 && ack_stb[i] && !irq_line[i]) |=> (st == 2'b10));

      a_r8_edge_repend: assert property (@(posedge clk) disable iff (!rst_n)
         (src_edge[i] && st == 2'b11 && eoi_stb[i]) |=> (st == 2'b01));

      a_r9_req_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
         core_req[i] |-> (st == 2'b01 && src_en[i]));

      a_r10_edge_merge_both: assert property (@(posedge clk) disable iff (!rst_n)
         (src_edge[i] && st == 2'b11 && !eoi_stb[i]) |=> (st == 2'b11));

      a_r10_edge_merge_pend: assert property (@(posedge clk) disable iff (!rst_n)
         (src_edge[i] && st == 2'b01 && !ack_stb[i]) |=> (st == 2'b01));

      a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (st == 2'b00 && !irq_line[i]) |=> (st == 2'b00));

      a_r12_level_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_edge[i] && st == 2'b01 && !ack_stb[i] && !irq_line[i]) |=> (st == 2'b00));

      a_r13_level_again: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_edge[i] && st[1] && eoi_stb[i] && irq_line[i]) |=> (st == 2'b01));
   end

endmodule

bind irq_lifecycle_bank irq_lc_checker #(.N_SRC(N_SRC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_line (irq_line),
   .src_en   (src_en),
   .src_edge (src_edge),
   .ack_stb  (ack_stb),
   .eoi_stb  (eoi_stb),
   .lc_state (lc_state),
   .core_req (core_req)
);

// File: tb/tb_irq_lifecycle_bank.sv
module tb_irq_lifecycle_bank;

   localparam int CLK_PERIOD = 10;
   localparam int N_SRC      = 4;
   localparam int PRIO_W     = 4;
   localparam int N_VEC      = 16;
   localparam int N_RAND     = 3000;

   // {lvl line,ack,eoi, edge line,ack,eoi, exp lvl state, exp edge state}
   // lvl lane drives sources 0,1 (level); edge lane drives sources 2,3 (edge)
   localparam logic [9:0] VEC [N_VEC] = '{
      10'b100_100_01_01, 10'b110_110_11_10, 10'b000_000_10_10, 10'b001_100_00_11,
      10'b010_000_00_11, 10'b100_100_01_11, 10'b000_101_00_01, 10'b001_001_00_01,
      10'b100_100_01_01, 10'b110_110_11_10, 10'b101_001_01_00, 10'b110_100_11_01,
      10'b101_110_01_10, 10'b010_010_10_10, 10'b100_101_11_01, 10'b001_000_00_01
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [N_SRC-1:0]        irq_line = '0;
   logic [N_SRC-1:0]        src_en = '0;
   logic [N_SRC-1:0]        src_edge = '0;
   logic [N_SRC-1:0]        ack_stb = '0;
   logic [N_SRC-1:0]        eoi_stb = '0;
   logic [N_SRC*PRIO_W-1:0] src_prio = '0;
   logic [PRIO_W-1:0]       prio_mask = '0;
   logic [2*N_SRC-1:0]      lc_state;
   logic [N_SRC-1:0]        core_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   irq_lifecycle_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) dut (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .src_en(src_en),
      .src_edge(src_edge), .ack_stb(ack_stb), .eoi_stb(eoi_stb),
      .src_prio(src_prio), .prio_mask(prio_mask),
      .lc_state(lc_state), .core_req(core_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string vec_tag(input int k);
      case (k)
         0: return "R2";         1: return "R3 R6";  2: return "R4";   3: return "R5 R7";
         4: return "R11";        5: return "R10";    6: return "R12 R8"; 7: return "R11";
         8: return "R10";        9: return "R3 R6";  10: return "R13"; 11: return "R13";
         12: return "R13";       13: return "R3 R11"; 14: return "R7"; default: return "R5";
      endcase
   endfunction

   // bench state model written from the requirements
   function automatic logic [1:0] ref_next(input logic em, input logic [1:0] s,
                                           input logic ln, input logic rs,
                                           input logic ak, input logic eo);
      logic [1:0] n = s;
      if (!em) begin
         case (s)
            2'b00: if (ln) n = 2'b01;
            2'b01: if (ak) n = ln ? 2'b11 : 2'b10; else if (!ln) n = 2'b00;
            2'b10: if (eo) n = ln ? 2'b01 : 2'b00; else if (ln) n = 2'b11;
            default: if (eo) n = ln ? 2'b01 : 2'b00; else if (!ln) n = 2'b10;
         endcase
      end else begin
         case (s)
            2'b00: if (rs) n = 2'b01;
            2'b01: if (ak) n = rs ? 2'b11 : 2'b10;
            2'b10: if (eo) n = rs ? 2'b01 : 2'b00; else if (rs) n = 2'b11;
            default: if (eo) n = 2'b01;
         endcase
      end
      return n;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq_line = '0; ack_stb = '0; eoi_stb = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 60000);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      if (!done) $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      src_edge  = 4'b1100;
      src_en    = 4'b0111;
      src_prio  = {4'd0, 4'd1, 4'd2, 4'd0};
      prio_mask = 4'd2;
      do_reset();
      // R1: reset state
      check("R1 state", 32'(lc_state), 32'h0);
      check("R1 req", 32'(core_req), 32'h0);

      // directed table walk
      for (int k = 0; k < N_VEC; k++) begin
         logic [1:0] el, ee;
         logic [3:0] er;
         @(negedge clk);
         irq_line = {VEC[k][6], VEC[k][6], VEC[k][9], VEC[k][9]};
         ack_stb  = {VEC[k][5], VEC[k][5], VEC[k][8], VEC[k][8]};
         eoi_stb  = {VEC[k][4], VEC[k][4], VEC[k][7], VEC[k][7]};
         el = VEC[k][3:2];
         ee = VEC[k][1:0];
         // R9/R8: only sources 0 and 2 are enabled and below the mask
         er = {1'b0, ee == 2'b01, 1'b0, el == 2'b01};
         @(posedge clk); #1;
         check(vec_tag(k), 32'(lc_state), 32'({ee, ee, el, el}));
         check({vec_tag(k), " R9 req"}, 32'(core_req), 32'(er));
      end

      // R9: source 2 waits; threshold and enable decide its request
      @(negedge clk);
      ack_stb = '0; eoi_stb = '0;
      prio_mask = 4'd1;
      #1 check("R9 mask equal blocks", 32'(core_req[2]), 32'h0);
      prio_mask = 4'd2;
      #1 check("R9 below mask", 32'(core_req[2]), 32'h1);
      src_en[2] = 1'b0;
      #1 check("R9 disabled", 32'(core_req[2]), 32'h0);
      src_en[2] = 1'b1;

      // R11: ack while idle leaves level source idle (lines low)
      @(negedge clk);
      ack_stb = 4'b0011; eoi_stb = 4'b0011;
      @(posedge clk); #1;
      check("R11 strobes in idle", 32'(lc_state[3:0]), 32'h0);

      // random phase against the bench model
      src_edge  = 4'b0101;
      prio_mask = 4'd3;
      src_prio  = {4'd1, 4'd2, 4'd3, 4'd0};
      do_reset();
      begin
         logic [1:0]       ms [N_SRC];
         logic [N_SRC-1:0] mprev;
         mprev = '0;
         for (int s = 0; s < N_SRC; s++) ms[s] = 2'b00;
         for (int c = 0; c < N_RAND; c++) begin
            logic [2*N_SRC-1:0] es;
            logic [N_SRC-1:0]   eq;
            @(negedge clk);
            for (int s = 0; s < N_SRC; s++) begin
               if ($urandom_range(0, 3) == 0) irq_line[s] = ~irq_line[s];
               ack_stb[s] = ($urandom_range(0, 3) == 0);
               eoi_stb[s] = ($urandom_range(0, 3) == 0);
               src_en[s]  = ($urandom_range(0, 4) != 0);
            end
            for (int s = 0; s < N_SRC; s++) begin
               ms[s] = ref_next(src_edge[s], ms[s], irq_line[s],
                                irq_line[s] & ~mprev[s], ack_stb[s], eoi_stb[s]);
               es[2*s +: 2] = ms[s];
               eq[s] = (ms[s] == 2'b01) && src_en[s] &&
                       (src_prio[PRIO_W*s +: PRIO_W] < prio_mask);
            end
            mprev = irq_line;
            @(posedge clk); #1;
            check("R2-R13 random state", 32'(lc_state), 32'(es));
            check("R9 random req", 32'(core_req), 32'(eq));
         end
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule